// File: doc/BRIEF.md
# Descriptor Ring Walker

This block follows two circular rings of 8-byte descriptors kept in host memory, one for receive and one for transmit. Software supplies a ring base address through a small byte-wide register port, picks a ring length for each direction, and then writes a kick register. The walker reads the descriptor at each direction's current slot over a single-beat memory port. It claims the slot and moves to the next one only when the descriptor's hardware-owned flag is set. When a direction reaches a descriptor it does not own, that direction stops until the next kick.

Each claimed slot is reported on a one-cycle handoff strobe. The strobe carries the direction, the slot index, the 12-bit length, the control byte and the buffer address, so that a downstream data mover can act on it. Both rings share one base: receive slots start at the base and transmit slots start 0x200 bytes above it. When both directions have work, the walker alternates between them.

Top module: `ring_slot_walker`

## Requirements
- R1: The ring base is built from three byte registers, with address bits 9..0 always zero. Offset 0x4 holds bits 17..10, offset 0x5 holds bits 25..18, and offset 0x2 holds bits 31..26 in its low six bits. The top two bits of offset 0x2 read back as zero. All three read back at their own offsets.
- R2: A receive descriptor is fetched from base + 8 × index. A transmit descriptor is fetched from base + 0x200 + 8 × index.
- R3: Offset 0x7 sets the ring lengths: the low nibble for receive and the high nibble for transmit. Codes 0x0, 0x1, 0x3, 0x7 and 0xF select 4, 8, 16, 32 and 64 slots. After a claim, the index becomes (index + 1) AND (length − 1).
- R4: The receive index reads at offset 0x0 and the transmit index at offset 0x1, each in bits 5..0 with bits 7..6 zero. An index changes only on a claim in its own direction.
- R5: The response beat is read as follows: bits 15..0 are the length, bits 31..24 the control byte, and bits 63..32 the buffer address. A slot is claimed, and its index advanced, only if bit 31 (control bit 7) is set.
- R6: A direction whose fetched descriptor is not owned stops making requests until the next kick.
- R7: A register write to offset 0x9 with data bit 0 set restarts both directions. A write to 0x9 with bit 0 clear has no effect.
- R8: Reset clears all registers and both indices, and no request is made until a kick.
- R9: A claim raises slot_take for exactly one cycle, in the cycle after the response beat. The strobe carries the claimed index, length bits 11..0, the control byte and the buffer address.
- R10: Only one request is outstanding at a time. A request that is not accepted holds its address until it is.
- R11: When both directions are active and both find owned slots, successive claims alternate between receive and transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_data | input | 64 | Descriptor contents |
| slot_take | output | 1 | Slot claimed (one-cycle pulse) |
| slot_dir | output | 1 | Claimed direction, 0 receive, 1 transmit |
| slot_index | output | 6 | Claimed slot index |
| slot_len | output | 12 | Claimed descriptor length |
| slot_ctrl | output | 8 | Claimed descriptor control byte |
| slot_buf_addr | output | 32 | Claimed buffer address |

## Verification
A corrupted index shows up within one fetch. The next request address points to the wrong slot, so the length and buffer address on the following slot_take differ from those predicted for that slot. The register readback at offsets 0x0 and 0x1 also differs once the run settles. A wrong pending or ownership decision shows up as a claim count that differs from the number of owned slots, or as a claim made without a kick, and is visible within a few cycles of the kick. A broken alternation shows up as two consecutive claims in one direction while the other direction still has owned slots.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int RSW_IDX_W  = 6;
  localparam int RSW_AW     = 32;
  localparam int RSW_RAW    = 5;

  localparam logic [RSW_RAW-1:0] OFS_RX_IDX    = 5'h00;
  localparam logic [RSW_RAW-1:0] OFS_TX_IDX    = 5'h01;
  localparam logic [RSW_RAW-1:0] OFS_BASE_TOP  = 5'h02;
  localparam logic [RSW_RAW-1:0] OFS_BASE_LOW  = 5'h04;
  localparam logic [RSW_RAW-1:0] OFS_BASE_MID  = 5'h05;
  localparam logic [RSW_RAW-1:0] OFS_RING_LEN  = 5'h07;
  localparam logic [RSW_RAW-1:0] OFS_KICK      = 5'h09;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_REQ  = 2'd1,
    WS_WAIT = 2'd2
  } walk_state_e;
endpackage

// File: rtl/rsw_rst_sync.sv
module rsw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/rsw_regs.sv
module rsw_regs
  import rsw_pkg::*;
#(
  parameter int IDX_W = RSW_IDX_W,
  parameter int AW    = RSW_AW,
  parameter int RAW   = RSW_RAW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RAW-1:0]       reg_addr,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  input  logic [IDX_W-1:0]     rx_idx,
  input  logic [IDX_W-1:0]     tx_idx,
  output logic [7:0]           reg_rdata,
  output logic [AW-IDX_W-5:0]  base_page,
  output logic [IDX_W-3:0]     rx_code,
  output logic [IDX_W-3:0]     tx_code,
  output logic                 kick
);
  localparam int TOP_W = AW - 26;

  logic [7:0]       low_q, mid_q, len_q;
  logic [TOP_W-1:0] top_q;
  logic             low_en, mid_en, top_en, len_en;

  always_comb begin
    low_en = reg_wr && (reg_addr == OFS_BASE_LOW);
    mid_en = reg_wr && (reg_addr == OFS_BASE_MID);
    top_en = reg_wr && (reg_addr == OFS_BASE_TOP);
    len_en = reg_wr && (reg_addr == OFS_RING_LEN);
    kick   = reg_wr && (reg_addr == OFS_KICK) && reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      mid_q <= '0;
      top_q <= '0;
      len_q <= '0;
    end else begin
      if (low_en) low_q <= reg_wdata;
      if (mid_en) mid_q <= reg_wdata;
      if (top_en) top_q <= reg_wdata[TOP_W-1:0];
      if (len_en) len_q <= reg_wdata;
    end
  end

  assign base_page = {top_q, mid_q, low_q};
  assign rx_code   = len_q[IDX_W-3:0];
  assign tx_code   = len_q[7:4];

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      OFS_RX_IDX:   reg_rdata = {{(8-IDX_W){1'b0}}, rx_idx};
      OFS_TX_IDX:   reg_rdata = {{(8-IDX_W){1'b0}}, tx_idx};
      OFS_BASE_TOP: reg_rdata = {{(8-TOP_W){1'b0}}, top_q};
      OFS_BASE_LOW: reg_rdata = low_q;
      OFS_BASE_MID: reg_rdata = mid_q;
      OFS_RING_LEN: reg_rdata = len_q;
      default:      reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rsw_index.sv
module rsw_index
  import rsw_pkg::*;
#(
  parameter int IDX_W = RSW_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IDX_W-3:0] len_code,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q, idx_d, wrap_mask;

  always_comb begin
    wrap_mask = {len_code, 2'b11};
    idx_d     = (idx_q + 1'b1) & wrap_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/rsw_fsm.sv
module rsw_fsm
  import rsw_pkg::*;
#(
  parameter int IDX_W = RSW_IDX_W,
  parameter int AW    = RSW_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 kick,
  input  logic [AW-IDX_W-5:0]  base_page,
  input  logic [IDX_W-1:0]     rx_idx,
  input  logic [IDX_W-1:0]     tx_idx,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [AW-1:0]        mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [11:0]          rsp_len,
  input  logic [7:0]           rsp_ctrl,
  input  logic [31:0]          rsp_buf,
  output logic [1:0]           advance,
  output logic                 slot_take,
  output logic                 slot_dir,
  output logic [IDX_W-1:0]     slot_index,
  output logic [11:0]          slot_len,
  output logic [7:0]           slot_ctrl,
  output logic [31:0]          slot_buf_addr
);
  walk_state_e      state_q, state_d;
  logic [1:0]       pend_q, pend_d;
  logic             dir_q, dir_d, last_q, last_d;
  logic             take_d, take_q;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] tidx_q;
  logic [11:0]      tlen_q;
  logic [7:0]       tctrl_q;
  logic [31:0]      tbuf_q;
  logic             tdir_q;

  assign cur_idx       = dir_q ? tx_idx : rx_idx;
  assign mem_req_valid = (state_q == WS_REQ);
  assign mem_req_addr  = {base_page, dir_q, cur_idx, 3'b000};

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    dir_d   = dir_q;
    last_d  = last_q;
    take_d  = 1'b0;
    advance = 2'b00;
    case (state_q)
      WS_IDLE: begin
        if (pend_q != 2'b00) begin
          dir_d   = (pend_q == 2'b11) ? ~last_q : pend_q[1];
          last_d  = dir_d;
          state_d = WS_REQ;
        end
      end
      WS_REQ: begin
        if (mem_req_ready) state_d = WS_WAIT;
      end
      WS_WAIT: begin
        if (mem_rsp_valid) begin
          if (rsp_ctrl[7]) begin
            advance[dir_q] = 1'b1;
            take_d         = 1'b1;
          end else begin
            pend_d[dir_q]  = 1'b0;
          end
          state_d = WS_IDLE;
        end
      end
      default: state_d = WS_IDLE;
    endcase
    if (kick) pend_d = 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      pend_q  <= 2'b00;
      dir_q   <= 1'b0;
      last_q  <= 1'b1;
      take_q  <= 1'b0;
      tdir_q  <= 1'b0;
      tidx_q  <= '0;
      tlen_q  <= '0;
      tctrl_q <= '0;
      tbuf_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      dir_q   <= dir_d;
      last_q  <= last_d;
      take_q  <= take_d;
      if (take_d) begin
        tdir_q  <= dir_q;
        tidx_q  <= cur_idx;
        tlen_q  <= rsp_len;
        tctrl_q <= rsp_ctrl;
        tbuf_q  <= rsp_buf;
      end
    end
  end

  assign slot_take     = take_q;
  assign slot_dir      = tdir_q;
  assign slot_index    = tidx_q;
  assign slot_len      = tlen_q;
  assign slot_ctrl     = tctrl_q;
  assign slot_buf_addr = tbuf_q;
endmodule

// File: rtl/ring_slot_walker.sv
module ring_slot_walker
  import rsw_pkg::*;
#(
  parameter int IDX_W = RSW_IDX_W,
  parameter int AW    = RSW_AW,
  parameter int RAW   = RSW_RAW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW-1:0]    reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              slot_take,
  output logic              slot_dir,
  output logic [IDX_W-1:0]  slot_index,
  output logic [11:0]       slot_len,
  output logic [7:0]        slot_ctrl,
  output logic [31:0]       slot_buf_addr
);
  localparam int NDIR = 2;

  logic                rst_n_s;
  logic [AW-IDX_W-5:0] base_page;
  logic [IDX_W-3:0]    code_w [NDIR];
  logic [IDX_W-1:0]    idx_w  [NDIR];
  logic [1:0]          advance;
  logic                kick;
  logic [IDX_W-1:0]    rx_idx_w, tx_idx_w;

  rsw_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rsw_regs #(.IDX_W(IDX_W), .AW(AW), .RAW(RAW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .rx_idx    (rx_idx_w),
    .tx_idx    (tx_idx_w),
    .reg_rdata (reg_rdata),
    .base_page (base_page),
    .rx_code   (code_w[0]),
    .tx_code   (code_w[1]),
    .kick      (kick)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    rsw_index #(.IDX_W(IDX_W)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .advance  (advance[d]),
      .len_code (code_w[d]),
      .idx      (idx_w[d])
    );
  end

  assign rx_idx_w = idx_w[0];
  assign tx_idx_w = idx_w[1];

  rsw_fsm #(.IDX_W(IDX_W), .AW(AW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .kick          (kick),
    .base_page     (base_page),
    .rx_idx        (rx_idx_w),
    .tx_idx        (tx_idx_w),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_len       (mem_rsp_data[11:0]),
    .rsp_ctrl      (mem_rsp_data[31:24]),
    .rsp_buf       (mem_rsp_data[63:32]),
    .advance       (advance),
    .slot_take     (slot_take),
    .slot_dir      (slot_dir),
    .slot_index    (slot_index),
    .slot_len      (slot_len),
    .slot_ctrl     (slot_ctrl),
    .slot_buf_addr (slot_buf_addr)
  );
endmodule

// File: rtl/rsw_checks.sv
module rsw_checks #(
  parameter int IDX_W = 6,
  parameter int AW    = 32,
  parameter int RAW   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RAW-1:0]   reg_addr,
  input logic [7:0]       reg_rdata,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             rsp_owned,
  input logic             slot_take,
  input logic             slot_dir,
  input logic [IDX_W-1:0] rx_idx,
  input logic [IDX_W-1:0] tx_idx
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_no_req_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  a_r5_take_needs_owned: assert property (@(posedge clk) disable iff (!rst_n)
    slot_take |-> $past(mem_rsp_valid && rsp_owned));

  a_r9_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    slot_take |=> !slot_take);

  a_r4_rx_moves_on_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_idx != $past(rx_idx)) |-> (slot_take && !slot_dir));

  a_r4_tx_moves_on_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idx != $past(tx_idx)) |-> (slot_take && slot_dir));

  a_r1_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 5'h02) |-> (reg_rdata[7:6] == 2'b00));
endmodule

bind ring_slot_walker rsw_checks #(.IDX_W(IDX_W), .AW(AW), .RAW(RAW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_addr      (reg_addr),
  .reg_rdata     (reg_rdata),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .rsp_owned     (mem_rsp_data[31]),
  .slot_take     (slot_take),
  .slot_dir      (slot_dir),
  .rx_idx        (rx_idx_w),
  .tx_idx        (tx_idx_w)
);

// File: tb/ring_slot_walker_tb.sv
module ring_slot_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        slot_take, slot_dir;
  logic [5:0]  slot_index;
  logic [11:0] slot_len;
  logic [7:0]  slot_ctrl;
  logic [31:0] slot_buf_addr;

  always #5 clk = ~clk;

  ring_slot_walker dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .slot_take(slot_take), .slot_dir(slot_dir),
    .slot_index(slot_index), .slot_len(slot_len), .slot_ctrl(slot_ctrl),
    .slot_buf_addr(slot_buf_addr)
  );

  localparam logic [31:0] BASE = {6'h3F, 8'h3C, 8'hA5, 10'b0};
  localparam int NV = 8;
  // ring length byte, receive slots owned, transmit slots owned
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'd3,  8'd2},
    {8'h00, 8'd2,  8'd3},
    {8'h11, 8'd8,  8'd0},
    {8'h33, 8'd5,  8'd16},
    {8'h77, 8'd31, 8'd7},
    {8'hFF, 8'd40, 8'd64},
    {8'hF0, 8'd0,  8'd1},
    {8'h0F, 8'd1,  8'd1}
  };

  int n_chk = 0, n_fail = 0;
  int req_cnt = 0, vec_takes = 0, rem_rx = 0, rem_tx = 0;
  int erx = 0, etx = 0;
  logic [7:0] sz = 8'h00;
  logic last_d = 1'b0;
  logic own_m [2][64];
  logic resp_pend = 1'b0;
  logic [31:0] lat_addr = '0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int msk(input logic [3:0] code);
    case (code)
      4'h0: return 3;
      4'h1: return 7;
      4'h3: return 15;
      4'h7: return 31;
      default: return 63;
    endcase
  endfunction

  function automatic logic [31:0] desc_addr(input logic d, input logic [5:0] i);
    return BASE + (d ? 32'h200 : 32'h0) + 32'(i) * 32'd8;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic set_owned(input int d, input int start, input int n, input int m);
    int i = start;
    for (int k = 0; k < n; k++) begin
      own_m[d][i] = 1'b1;
      i = (i + 1) & m;
    end
  endtask

  // memory responder and claim monitor
  initial begin
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_req_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (resp_pend) begin
        logic o;
        o = own_m[lat_addr[9]][lat_addr[8:3]];
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = {~lat_addr, (o ? 8'hC5 : 8'h45), 8'h3E, 4'hC, lat_addr[14:3]};
        resp_pend = 1'b0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = ~mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        resp_pend = 1'b1;
        lat_addr  = mem_req_addr;
        req_cnt++;
      end
      if (slot_take) begin
        logic [31:0] da;
        int ex;
        ex = slot_dir ? etx : erx;
        chk(slot_index == 6'(ex), "R5 claimed index", slot_index, ex);
        da = desc_addr(slot_dir, slot_index);
        chk(slot_buf_addr == ~da, "R2 descriptor address", slot_buf_addr, ~da);
        chk(slot_len == da[14:3], "R9 length field", slot_len, da[14:3]);
        chk(slot_ctrl == 8'hC5, "R9 control byte", slot_ctrl, 8'hC5);
        if (vec_takes > 0 && slot_dir == last_d)
          chk((slot_dir ? rem_rx : rem_tx) == 0, "R11 alternation", slot_dir, ~slot_dir);
        own_m[slot_dir][slot_index] = 1'b0;
        if (slot_dir) begin etx = (etx + 1) & msk(sz[7:4]); rem_tx--; end
        else          begin erx = (erx + 1) & msk(sz[3:0]); rem_rx--; end
        last_d = slot_dir;
        vec_takes++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int r0;
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 64; i++) own_m[d][i] = 1'b0;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state
    chk(mem_req_valid == 1'b0, "R8 no request after reset", mem_req_valid, 0);
    rd(5'h00, v); chk(v == 8'h00, "R8 rx index reset", v, 0);
    rd(5'h01, v); chk(v == 8'h00, "R8 tx index reset", v, 0);
    rd(5'h07, v); chk(v == 8'h00, "R8 ring length reset", v, 0);

    // R1 base registers
    wr(5'h04, 8'hA5); wr(5'h05, 8'h3C); wr(5'h02, 8'hFF);
    rd(5'h02, v); chk(v == 8'h3F, "R1 top base bits", v, 8'h3F);
    rd(5'h04, v); chk(v == 8'hA5, "R1 low base byte", v, 8'hA5);
    rd(5'h05, v); chk(v == 8'h3C, "R1 mid base byte", v, 8'h3C);
    chk(req_cnt == 0, "R8 idle before kick", req_cnt, 0);

    for (int k = 0; k < NV; k++) begin
      int nrx, ntx;
      sz  = VEC[k][23:16];
      nrx = int'(VEC[k][15:8]);
      ntx = int'(VEC[k][7:0]);
      wr(5'h07, sz);
      set_owned(0, erx, nrx, msk(sz[3:0]));
      set_owned(1, etx, ntx, msk(sz[7:4]));
      vec_takes = 0; rem_rx = nrx; rem_tx = ntx;
      wr(5'h09, 8'h01);
      repeat (8 * (nrx + ntx) + 40) @(negedge clk);
      chk(vec_takes == nrx + ntx, "R5 claims equal owned slots", vec_takes, nrx + ntx);
      rd(5'h00, v); chk(v == 8'(erx), "R3 rx index wrap", v, erx);
      rd(5'h01, v); chk(v == 8'(etx), "R4 tx index readback", v, etx);
    end

    // R6: ownership appears without a kick, nothing happens
    vec_takes = 0; rem_rx = 1; rem_tx = 0;
    r0 = req_cnt;
    set_owned(0, erx, 1, msk(sz[3:0]));
    repeat (30) @(negedge clk);
    chk(req_cnt == r0, "R6 stopped after unowned slot", req_cnt, r0);
    // R7: write with bit 0 clear is ignored
    wr(5'h09, 8'h02);
    repeat (30) @(negedge clk);
    chk(vec_takes == 0, "R7 kick with bit0 clear ignored", vec_takes, 0);
    rd(5'h00, v); chk(v == 8'(erx), "R7 index unchanged", v, erx);
    wr(5'h09, 8'h01);
    repeat (40) @(negedge clk);
    chk(vec_takes == 1, "R7 kick restarts", vec_takes, 1);

    // R8 reset in the middle of activity state
    @(negedge clk); rst_n = 1'b0;
    rd(5'h00, v); chk(v == 8'h00, "R8 rx index cleared", v, 0);
    rd(5'h01, v); chk(v == 8'h00, "R8 tx index cleared", v, 0);
    erx = 0; etx = 0;
    own_m[0][0] = 1'b1;
    r0 = req_cnt;
    @(negedge clk); rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(req_cnt == r0, "R8 idle after reset until kick", req_cnt, r0);
    rd(5'h02, v); chk(v == 8'h00, "R8 base cleared", v, 0);

    finish_run();
  end
endmodule